// File: doc/BRIEF.md
# Reference-Compare Error Detector

This block watches a set of digitized output channels from a unit under test. It compares them, channel by channel, with the outputs of a known-good reference that receives the same stimulus. Both vectors are sampled on every rising edge of the sample clock. A channel counts as mismatching on a sample when its two bits differ.

A short disagreement comes from propagation skew between the two devices, so the block ignores it. A disagreement that lasts long enough is qualified as an error. Every qualified error lights that channel's indicator and holds it on for a long, human-visible interval. A mismatch that persists keeps the indicator lit without a break. A sticky summary flag records that any channel has qualified an error since it was last cleared.

The block has three time limits, all counted in clock cycles:
- the longest run that is treated as skew;
- the run length at which a mismatch qualifies;
- the run length by which detection is guaranteed.

The qualify point is held inside the window set by the other two. A fourth parameter sets the stretch length.

Top module: `ref_compare_detector`

## Requirements
- R1: On each rising clock edge, channel i mismatches when `dut_out[i]` differs from `gold_out[i]`, and a mismatch on channel i affects only `err_ind[i]`.
- R2: A run of `SKEW_CYC` or fewer consecutive mismatching samples never sets `err_ind` or `any_err`.
- R3: A run of `DETECT_CYC` or more consecutive mismatching samples always qualifies, even when it is a single isolated event.
- R4: A run qualifies on the edge that samples its `QUAL_CYC`-th consecutive mismatch, and `err_ind` is high after that edge. One matching sample restarts the run count, so two short runs split by a single match never add up.
- R5: After the last edge at which a channel is qualified, `err_ind` stays high for exactly `STRETCH_CYC` cycles. A new qualification during the stretch restarts the interval from that edge.
- R6: While a qualified mismatch persists, every edge counts as a qualifying edge, so `err_ind` stays high continuously.
- R7: `any_err` goes high after any edge that qualifies a new run on any channel. It then stays high until an edge samples `clr_flag` high with no new qualification on that edge. A new qualification on the same edge as a clear leaves the flag set. `clr_flag` does not affect `err_ind`.
- R8: An edge with `rst` high (synchronous, active high) clears every run count, every indicator and `any_err`.
- R9: Channels are independent: run counts and stretch timers on one channel are unaffected by activity on any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_flag | input | 1 | Clears the sticky summary flag |
| dut_out | input | CH | Digitized outputs of the unit under test |
| gold_out | input | CH | Digitized outputs of the reference |
| err_ind | output | CH | Stretched per-channel error indicator |
| any_err | output | 1 | Sticky flag: some channel qualified an error |

## Verification
The bench applies directed runs at lengths below, at and above the qualify point:
- Runs at the skew limit and one short of qualification must stay silent. Runs at exactly the qualify length and at the guaranteed-detection length must light the indicator on the right edge.
- Two short runs split by one matching sample separate a counter that restarts from one that accumulates.
- A long static mismatch and a second qualification during an active stretch separate a continuous hold and a stretch restart from a single fixed-length pulse.
- Clears during a quiet interval and on the same edge as a qualification expose the priority of the summary flag.
- Random per-channel mismatch bursts on random data exercise channel independence against a model written in terms of qualifying-edge timestamps.

// File: rtl/rcmp_pkg.sv
package rcmp_pkg;

  // Keep the qualify point inside (skew, detect].
  function automatic int unsigned qual_clamp(input int unsigned skew,
                                             input int unsigned qual,
                                             input int unsigned detect);
    int unsigned q;
    q = qual;
    if (q <= skew)  q = skew + 1;
    if (q > detect) q = detect;
    if (q == 0)     q = 1;
    return q;
  endfunction

  // Run-length update: restart on agreement, saturate at the limit.
  function automatic int unsigned run_next(input int unsigned run,
                                           input logic        diff,
                                           input int unsigned limit);
    if (!diff)          return 0;
    else if (run < limit) return run + 1;
    else                return limit;
  endfunction

  // Stretch timer update: reload on a qualifying edge, else count down to 0.
  function automatic int unsigned stretch_next(input int unsigned cnt,
                                               input logic        load,
                                               input int unsigned len);
    if (load)          return len;
    else if (cnt != 0) return cnt - 1;
    else               return 0;
  endfunction

endpackage

// File: rtl/mismatch_filter.sv
module mismatch_filter
  import rcmp_pkg::*;
#(
  parameter int unsigned QUAL_CYC = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic diff_i,
  output logic first_o,  // this edge completes the qualifying run
  output logic hold_o    // run already qualified and still mismatching
);
  localparam int unsigned CW = $clog2(QUAL_CYC + 1);
  localparam logic [CW-1:0] QMAX  = CW'(QUAL_CYC);
  localparam logic [CW-1:0] QPREV = CW'(QUAL_CYC - 1);

  logic [CW-1:0] run_q;

  assign first_o = diff_i && (run_q == QPREV);
  assign hold_o  = diff_i && (run_q == QMAX);

  always_ff @(posedge clk) begin
    if (rst) run_q <= '0;
    else     run_q <= CW'(run_next(32'(run_q), diff_i, QUAL_CYC));
  end

  // R4: a run qualifies only once
  p_single_first_r4: assert property (@(posedge clk) disable iff (rst)
    first_o |=> !first_o);
  // R4: after a qualifying edge, continued mismatch is seen as held
  p_first_then_hold_r4: assert property (@(posedge clk) disable iff (rst)
    first_o && $past(1'b1) |=> (diff_i == hold_o));
  // R1: agreement never qualifies
  p_agree_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !diff_i |-> !(first_o || hold_o));

endmodule

// File: rtl/err_stretcher.sv
module err_stretcher
  import rcmp_pkg::*;
#(
  parameter int unsigned STRETCH_CYC = 25_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  output logic ind_o
);
  localparam int unsigned SW = $clog2(STRETCH_CYC + 1);

  logic [SW-1:0] left_q;

  assign ind_o = (left_q != '0);

  always_ff @(posedge clk) begin
    if (rst) left_q <= '0;
    else     left_q <= SW'(stretch_next(32'(left_q), load_i, STRETCH_CYC));
  end

  // R5: a qualifying edge always lights the indicator
  p_load_lights_r5: assert property (@(posedge clk) disable iff (rst)
    load_i |=> ind_o);
  // R5: the indicator cannot drop right after a load
  p_no_drop_on_load_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(ind_o) |-> !$past(load_i));

endmodule

// File: rtl/ref_compare_detector.sv
module ref_compare_detector
  import rcmp_pkg::*;
#(
  parameter int unsigned CH          = 16,
  parameter int unsigned SKEW_CYC    = 12,
  parameter int unsigned QUAL_CYC    = 25,
  parameter int unsigned DETECT_CYC  = 50,
  parameter int unsigned STRETCH_CYC = 25_000_000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_flag,
  input  logic [CH-1:0] dut_out,
  input  logic [CH-1:0] gold_out,
  output logic [CH-1:0] err_ind,
  output logic          any_err
);
  localparam int unsigned QUAL_EFF = qual_clamp(SKEW_CYC, QUAL_CYC, DETECT_CYC);

  logic [CH-1:0] diff_w;
  logic [CH-1:0] first_w;
  logic [CH-1:0] hold_w;
  logic          new_err_w;

  assign diff_w    = dut_out ^ gold_out;
  assign new_err_w = |first_w;

  for (genvar g = 0; g < CH; g++) begin : g_lane
    mismatch_filter #(.QUAL_CYC(QUAL_EFF)) u_filt (
      .clk     (clk),
      .rst     (rst),
      .diff_i  (diff_w[g]),
      .first_o (first_w[g]),
      .hold_o  (hold_w[g])
    );
    err_stretcher #(.STRETCH_CYC(STRETCH_CYC)) u_str (
      .clk    (clk),
      .rst    (rst),
      .load_i (first_w[g] | hold_w[g]),
      .ind_o  (err_ind[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)            any_err <= 1'b0;
    else if (new_err_w) any_err <= 1'b1;
    else if (clr_flag)  any_err <= 1'b0;
  end

  // R7: a new qualification sets the flag even against a clear
  p_flag_set_r7: assert property (@(posedge clk) disable iff (rst)
    new_err_w |=> any_err);
  // R7: the flag only drops on a clear
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    any_err && !clr_flag |=> any_err);
  // R6: a held mismatch keeps its indicator lit
  p_static_lit_r6: assert property (@(posedge clk) disable iff (rst)
    |hold_w |=> |err_ind);
  // R8: reset clears the outputs
  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (err_ind == '0) && !any_err);

endmodule

// File: tb/ref_compare_detector_test.sv
`timescale 1ns/1ps
module ref_compare_detector_test;
  localparam int CH = 16;
  localparam int SKEW = 12;
  localparam int QUAL = 25;
  localparam int DET = 50;
  localparam int STR = 300;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr = 1'b0;
  logic [CH-1:0] dut_v = '0;
  logic [CH-1:0] gold_v = '0;
  logic [CH-1:0] err_ind;
  logic any_err;

  always #2 clk = ~clk;  // 250 MHz

  ref_compare_detector #(
    .CH(CH), .SKEW_CYC(SKEW), .QUAL_CYC(QUAL),
    .DETECT_CYC(DET), .STRETCH_CYC(STR)
  ) uut (
    .clk(clk), .rst(rst), .clr_flag(clr),
    .dut_out(dut_v), .gold_out(gold_v),
    .err_ind(err_ind), .any_err(any_err)
  );

  int vectors = 0;
  int miscompares = 0;
  int edge_n = 0;
  int run_len [CH];
  int last_q [CH];
  logic exp_any = 1'b0;
  logic model_ok = 1'b0;

  // Expected indicator: lit while fewer than STR edges have passed since the
  // most recent edge at which the channel's run was at least QUAL long.
  function automatic logic [CH-1:0] exp_ind();
    logic [CH-1:0] v;
    for (int i = 0; i < CH; i++) v[i] = (edge_n - last_q[i]) < STR;
    return v;
  endfunction

  task automatic model_edge(input logic [CH-1:0] dm, input logic c, input logic r);
    logic fresh;
    edge_n++;
    fresh = 1'b0;
    if (r) begin
      for (int i = 0; i < CH; i++) begin
        run_len[i] = 0;
        last_q[i] = -1000000;
      end
      exp_any = 1'b0;
      return;
    end
    for (int i = 0; i < CH; i++) begin
      run_len[i] = dm[i] ? run_len[i] + 1 : 0;
      if (run_len[i] >= QUAL) last_q[i] = edge_n;
      if (run_len[i] == QUAL) fresh = 1'b1;
    end
    if (fresh) exp_any = 1'b1;
    else if (c) exp_any = 1'b0;
  endtask

  task automatic check(input string req);
    logic [CH-1:0] e;
    e = exp_ind();
    vectors++;
    if (err_ind !== e || any_err !== exp_any) begin
      miscompares++;
      $display("FAIL %s edge %0d: ind=%h any=%b expected ind=%h any=%b",
               req, edge_n, err_ind, any_err, e, exp_any);
    end
  endtask

  task automatic step(input logic [CH-1:0] rv, input logic [CH-1:0] dm,
                      input logic c, input logic r, input string req);
    @(negedge clk);
    if (model_ok) check(req);
    gold_v = rv;
    dut_v = rv ^ dm;
    clr = c;
    rst = r;
    model_edge(dm, c, r);
    model_ok = 1'b1;
  endtask

  task automatic burst(input int ch, input int len, input string req);
    for (int k = 0; k < len; k++) step(16'h5a3c, CH'(1) << ch, 1'b0, 1'b0, req);
    step(16'h5a3c, '0, 1'b0, 1'b0, req);
  endtask

  task automatic quiet(input int n, input string req);
    for (int k = 0; k < n; k++) step(CH'($urandom), '0, 1'b0, 1'b0, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [CH-1:0] dstate;
    void'($urandom(32'd2024));
    for (int i = 0; i < CH; i++) begin run_len[i] = 0; last_q[i] = -1000000; end
    // R8: reset state
    step('0, '0, 1'b0, 1'b1, "R8");
    step('0, '0, 1'b0, 1'b1, "R8");
    quiet(3, "R8");
    // R2: runs at the skew limit stay silent
    burst(0, SKEW, "R2");
    burst(0, 1, "R2");
    quiet(5, "R2");
    // R4: one short of qualify stays silent
    burst(1, QUAL - 1, "R4");
    quiet(5, "R4");
    // R4: two short runs split by one match do not add
    burst(2, QUAL - 2, "R4");
    burst(2, QUAL - 2, "R4");
    quiet(5, "R4");
    // R4: exact qualify length lights the channel, R5 stretch length
    burst(3, QUAL, "R4");
    quiet(STR + 5, "R5");
    // R7: clear during a quiet interval
    step('0, '0, 1'b1, 1'b0, "R7");
    quiet(3, "R7");
    // R3: isolated run at the detection limit
    burst(4, DET, "R3");
    quiet(40, "R3");
    // R7: clear on the same edge as a new qualification
    step('0, '0, 1'b1, 1'b0, "R7");
    for (int k = 0; k < QUAL - 1; k++) step('0, CH'(1) << 5, 1'b0, 1'b0, "R7");
    step('0, CH'(1) << 5, 1'b1, 1'b0, "R7");
    step('0, '0, 1'b0, 1'b0, "R7");
    quiet(STR + 5, "R7");
    // R5: second qualification mid-stretch restarts the interval
    burst(6, QUAL, "R5");
    quiet(100, "R5");
    burst(6, QUAL, "R5");
    quiet(STR + 5, "R5");
    // R6: static mismatch holds the indicator on
    for (int k = 0; k < 600; k++) step(CH'($urandom), CH'(1) << 7, 1'b0, 1'b0, "R6");
    quiet(STR + 5, "R6");
    // R9: one channel busy, another short runs
    for (int k = 0; k < 60; k++)
      step(CH'($urandom), (CH'(1) << 8) | ((k % 10) < 5 ? CH'(1) << 9 : '0), 1'b0, 1'b0, "R9");
    quiet(STR + 5, "R9");
    // R1: random per-channel bursts on random data
    dstate = '0;
    for (int k = 0; k < 6000; k++) begin
      for (int i = 0; i < CH; i++)
        if ($urandom % 20 == 0) dstate[i] = ~dstate[i];
      step(CH'($urandom), dstate, ($urandom % 97) == 0, 1'b0, "R1");
    end
    // R8: reset mid-activity
    step('0, '1, 1'b0, 1'b1, "R8");
    quiet(3, "R8");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule